// File: doc/BRIEF.md
# Rotating-Context Interleaved Memory Fabric

This block lets several minimal processor contexts share one embedded instruction memory with no crossbar and no arbiter. The memory is split into `NSLOT` single-port banks, and an address lives in bank `address mod NSLOT`. Each execution slot is wired to one bank only: slot k reads bank k. The contexts move instead of the requests. On every clock edge, the whole record of each context (valid flag, program counter, accumulator) passes from slot k to slot k+1, and the last slot feeds slot 0.

A context whose program counter runs straight ahead therefore always arrives at the slot that owns its next address. While no context jumps, all contexts use distinct banks in every cycle. After a jump, the target may belong to a bank other than the one the next slot faces. The context then rides the ring as a bubble, with its state unchanged, until it reaches the owning slot. It never holds up any other context.

The processor itself is reduced to a four-operation accumulator model. A load port fills the banks. An injection port places new contexts into free ring positions.

Top module: `rr_fabric`

## Requirements
- R1: After reset every slot is empty: `exe_vld` stays all zero until a context is injected, and the first injection request is accepted.
- R2: An address belongs to bank `pc[1:0]` (address mod 4) at row `pc[8:2]`; bits `pc[11:9]` alias. Slot k executes only addresses with `pc mod 4 == k`, so no two slots use the same bank in one cycle.
- R3: Every context record moves from slot k to slot (k+1) mod 4 on each clock edge, and no context is ever lost. After an ADD or LDI executes in slot k, the same context executes in slot k+1 in the next cycle (unless the load port blocks that bank).
- R4: After a context executes at `p` and continues at `q`, its next execution comes exactly `((q - p - 1) mod 4) + 1` cycles later (plus 4 for each load-port block it meets), whatever the other contexts do.
- R5: While a context passes slots that do not own its address, its PC and accumulator stay unchanged.
- R6: Instruction word: bits [13:12] are the operation and bits [11:0] are the immediate. 00 ADD: acc = acc + imm mod 4096, pc+1. 01 LDI: acc = imm, pc+1. 10 JMP: pc = imm. 11 JNZ: pc = imm if acc != 0, else pc+1. `exe_pc` gives the executed address and `exe_acc` the accumulator after the operation.
- R7: `wr_en` writes `wr_data` into bank `wr_addr mod 4` at row `wr_addr[8:2]`. In that cycle the bank's single port serves the write, so the slot facing it does not execute.
- R8: `ins_en` places a context {`ins_pc`, `ins_acc`} into slot 0 only when the record arriving at slot 0 is empty, and `ins_ack` reports this. A refused request changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load-port write strobe |
| wr_addr | input | 12 | Load-port word address |
| wr_data | input | 14 | Load-port instruction word |
| ins_en | input | 1 | Request to inject a context |
| ins_pc | input | 12 | Start address of injected context |
| ins_acc | input | 12 | Initial accumulator of injected context |
| ins_ack | output | 1 | Injection accepted this cycle |
| exe_vld | output | 4 | Per-slot: an instruction executes this cycle |
| exe_pc | output | 48 | Per-slot executed address, slot k at [12k+11:12k] |
| exe_acc | output | 48 | Per-slot accumulator after execution, slot k at [12k+11:12k] |

## Verification
The bench builds the block with its defaults: four slots and 512 instruction words, so 128 rows per bank. With four contexts injected, every ring position is occupied, and the programs contain jumps whose targets need 1, 2, 3 and 4 cycles to realign. Every bubble length and every pair of neighbouring contexts is therefore reached. Writes to a scratch region while the ring is full make each bank lose its port in turn, so the extra revolution a blocked context takes is also exercised.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int WORD_W = 12;
    localparam int OP_W   = 2;
    localparam int INST_W = OP_W + WORD_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'd0,
        OP_LDI = 2'd1,
        OP_JMP = 2'd2,
        OP_JNZ = 2'd3
    } op_e;

    // Everything a context owns; this is what hops between slots.
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] acc;
    } ctx_t;
endpackage

// File: rtl/rr_bank.sv
module rr_bank #(
    parameter int DEPTH = 128,
    parameter int W     = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [W-1:0]             wdata_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_i,
    output logic [W-1:0]             rdata_o
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] port_a;

    // One port: a write takes the address and the slot's read is lost.
    assign port_a  = we_i ? waddr_i : raddr_i;
    assign rdata_o = mem_q[port_a];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[port_a] <= wdata_i;
        end
    end
endmodule

// File: rtl/rr_slot.sv
module rr_slot import rr_pkg::*; #(
    parameter int NSLOT = 4,
    parameter int SLOT  = 0
) (
    input  ctx_t              cur_i,
    input  logic [INST_W-1:0] inst_i,
    input  logic              blk_i,
    output ctx_t              nxt_o,
    output logic              exe_o
);
    localparam int SEL_W = $clog2(NSLOT);

    op_e               op;
    logic [WORD_W-1:0] imm;
    logic              go;

    always_comb begin
        op    = op_e'(inst_i[INST_W-1 -: OP_W]);
        imm   = inst_i[WORD_W-1:0];
        go    = cur_i.vld && (cur_i.pc[SEL_W-1:0] == SEL_W'(SLOT)) && !blk_i;
        nxt_o = cur_i;
        if (go) begin
            unique case (op)
                OP_ADD: begin nxt_o.acc = cur_i.acc + imm; nxt_o.pc = cur_i.pc + 1'b1; end
                OP_LDI: begin nxt_o.acc = imm;             nxt_o.pc = cur_i.pc + 1'b1; end
                OP_JMP: nxt_o.pc = imm;
                OP_JNZ: nxt_o.pc = (cur_i.acc != '0) ? imm : cur_i.pc + 1'b1;
                default: nxt_o = cur_i;
            endcase
        end
        exe_o = go;
    end
endmodule

// File: rtl/rr_fabric.sv
module rr_fabric import rr_pkg::*; #(
    parameter int NSLOT     = 4,
    parameter int MEM_WORDS = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [WORD_W-1:0]       wr_addr,
    input  logic [INST_W-1:0]       wr_data,
    input  logic                    ins_en,
    input  logic [WORD_W-1:0]       ins_pc,
    input  logic [WORD_W-1:0]       ins_acc,
    output logic                    ins_ack,
    output logic [NSLOT-1:0]        exe_vld,
    output logic [NSLOT*WORD_W-1:0] exe_pc,
    output logic [NSLOT*WORD_W-1:0] exe_acc
);
    localparam int SEL_W      = $clog2(NSLOT);
    localparam int BANK_DEPTH = MEM_WORDS / NSLOT;
    localparam int ROW_W      = $clog2(BANK_DEPTH);
    localparam int HI_W       = WORD_W - SEL_W - ROW_W;

    typedef struct packed {
        ctx_t [NSLOT-1:0] ring;
    } st_t;

    st_t               st_d, st_q;
    ctx_t              nxt  [NSLOT];
    logic [INST_W-1:0] inst [NSLOT];
    logic [NSLOT-1:0]  blk;
    logic [NSLOT-1:0]  vld_vec;
    logic [SEL_W-1:0]  wr_bank;
    logic [ROW_W-1:0]  wr_row;
    logic [HI_W-1:0]   unused_wr_hi;

    assign wr_bank      = wr_addr[SEL_W-1:0];
    assign wr_row       = wr_addr[SEL_W +: ROW_W];
    assign unused_wr_hi = wr_addr[WORD_W-1 -: HI_W];

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        localparam int KN = (k + 1) % NSLOT;

        assign blk[k]     = wr_en && (wr_bank == SEL_W'(k));
        assign vld_vec[k] = st_q.ring[k].vld;

        rr_bank #(.DEPTH(BANK_DEPTH), .W(INST_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (blk[k]),
            .waddr_i (wr_row),
            .wdata_i (wr_data),
            .raddr_i (st_q.ring[k].pc[SEL_W +: ROW_W]),
            .rdata_o (inst[k])
        );

        rr_slot #(.NSLOT(NSLOT), .SLOT(k)) u_slot (
            .cur_i  (st_q.ring[k]),
            .inst_i (inst[k]),
            .blk_i  (blk[k]),
            .nxt_o  (nxt[k]),
            .exe_o  (exe_vld[k])
        );

        assign exe_pc [k*WORD_W +: WORD_W] = st_q.ring[k].pc;
        assign exe_acc[k*WORD_W +: WORD_W] = nxt[k].acc;

        // R5
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.ring[k].vld && !exe_vld[k]) |=>
            (st_q.ring[KN].vld && st_q.ring[KN].pc == $past(st_q.ring[k].pc)
             && st_q.ring[KN].acc == $past(st_q.ring[k].acc)));

        // R3
        seq_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (exe_vld[k] && !inst[k][INST_W-1]) |=> (exe_vld[KN] || blk[KN]));
    end

    always_comb begin
        st_d    = st_q;
        ins_ack = ins_en && !nxt[NSLOT-1].vld;
        for (int k = 0; k < NSLOT; k++) st_d.ring[(k + 1) % NSLOT] = nxt[k];
        if (ins_ack) begin
            st_d.ring[0].vld = 1'b1;
            st_d.ring[0].pc  = ins_pc;
            st_d.ring[0].acc = ins_acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    ins_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ack |=> (st_q.ring[0].vld && st_q.ring[0].pc == $past(ins_pc)
                     && st_q.ring[0].acc == $past(ins_acc)));

    // R3
    ctx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld_vec) >= $past($countones(vld_vec)));
endmodule

// File: tb/rr_fabric_test.sv
module rr_fabric_test;
    import rr_pkg::*;

    localparam int N     = 4;
    localparam int W     = 12;
    localparam int NCTX  = 4;
    localparam int STEPS = 30;
    localparam int MEMW  = 512;
    localparam int REG   = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [W-1:0] wr_addr = '0;
    logic [INST_W-1:0] wr_data = '0;
    logic ins_en = 1'b0;
    logic [W-1:0] ins_pc = '0;
    logic [W-1:0] ins_acc = '0;
    logic ins_ack;
    logic [N-1:0] exe_vld;
    logic [N*W-1:0] exe_pc, exe_acc;

    always #10 clk = ~clk;

    rr_fabric #(.NSLOT(N), .MEM_WORDS(MEMW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ins_en(ins_en), .ins_pc(ins_pc), .ins_acc(ins_acc), .ins_ack(ins_ack),
        .exe_vld(exe_vld), .exe_pc(exe_pc), .exe_acc(exe_acc)
    );

    typedef struct { int pc; int acc; } exp_t;

    int total = 0, bad = 0, cyc = 0;
    bit running = 0, done = 0;
    logic [INST_W-1:0] img [MEMW];
    exp_t expq [NCTX][$];
    int last_cyc [NCTX];
    int last_pc  [NCTX];
    int wlog [16];

    always @(posedge clk) cyc++;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(int a, int op, int imm);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = W'(a);
        wr_data = {op[1:0], imm[W-1:0]};
        img[a % MEMW] = {op[1:0], imm[W-1:0]};
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Driver side of the scoreboard: one instruction-level model per context.
    task automatic build_ref(int c, int pc0, int acc0);
        int pc = pc0, acc = acc0, npc, op, imm;
        for (int s = 0; s < STEPS; s++) begin
            op  = int'(img[pc % MEMW][INST_W-1 -: 2]);
            imm = int'(img[pc % MEMW][W-1:0]);
            npc = (pc + 1) % 4096;
            case (op)
                0: acc = (acc + imm) % 4096;
                1: acc = imm;
                2: npc = imm;
                default: if (acc != 0) npc = imm;
            endcase
            expq[c].push_back('{pc: pc, acc: acc});
            pc = npc;
        end
    endtask

    // Monitor side: pops and compares each execution as it appears.
    always @(negedge clk) begin
        if (running) begin
            int pc, acc, c, d, seen [N];
            exp_t e;
            for (int b = 0; b < N; b++) seen[b] = 0;
            wlog[cyc % 16] = wr_en ? int'(wr_addr) % N : -1;
            if (wr_en)
                chk(exe_vld[int'(wr_addr) % N] == 1'b0, "R7", "blocked bank slot executed",
                    int'(exe_vld[int'(wr_addr) % N]), 0);
            for (int k = 0; k < N; k++) begin
                if (exe_vld[k]) begin
                    pc  = int'(exe_pc [k*W +: W]);
                    acc = int'(exe_acc[k*W +: W]);
                    seen[pc % N]++;
                    chk(pc % N == k, "R2", "slot executes foreign bank", pc % N, k);
                    if (pc >= NCTX * REG) begin
                        chk(0, "R8", "refused context executed", pc, -1);
                    end else begin
                        c = pc / REG;
                        if (expq[c].size() > 0) begin
                            e = expq[c].pop_front();
                            chk(pc == e.pc, "R6", "executed address", pc, e.pc);
                            chk(acc == e.acc, (last_cyc[c] >= 0 && cyc - last_cyc[c] > 1) ? "R5" : "R6",
                                "accumulator after step", acc, e.acc);
                        end
                        if (last_cyc[c] >= 0) begin
                            d = ((pc - last_pc[c] - 1) % N + N) % N + 1;
                            while (d < 16 && wlog[(last_cyc[c] + d) % 16] == pc % N) d += N;
                            chk(cyc - last_cyc[c] == d, (pc == last_pc[c] + 1) ? "R3" : "R4",
                                "cycles between executions", cyc - last_cyc[c], d);
                        end
                        last_cyc[c] = cyc;
                        last_pc[c]  = pc;
                    end
                end
            end
            for (int b = 0; b < N; b++)
                if (seen[b] > 1) chk(0, "R2", "bank used twice in a cycle", seen[b], 1);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish act=%0d exp=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEMW; i++) img[i] = '0;
        for (int i = 0; i < 16; i++) wlog[i] = -1;
        for (int c = 0; c < NCTX; c++) begin last_cyc[c] = -1; last_pc[c] = 0; end

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: ring empty after reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(exe_vld == '0, "R1", "execution with empty ring", int'(exe_vld), 0);
        end

        // ctx0: countdown loop, jumps needing 3 and 4 cycles (R4)
        put(0, 1, 3); put(1, 0, 12'hFFF); put(2, 3, 1); put(3, 2, 7); put(7, 0, 10); put(8, 2, 0);
        // ctx1: starts misaligned, jumps needing 2 and 3 cycles
        put(66, 1, 1); put(67, 0, 1); put(68, 2, 70); put(70, 0, 2); put(71, 3, 66);
        // ctx2: jump to next address (no bubble) and a 2-cycle jump
        put(128, 0, 7); put(129, 2, 130); put(130, 0, 1); put(131, 2, 129);
        // ctx3: JNZ not taken, accumulator wrap at 4096
        put(195, 1, 0); put(196, 3, 200); put(197, 0, 12'h800); put(198, 0, 12'h800);
        put(199, 3, 195); put(200, 2, 195);

        build_ref(0, 0, 0);
        build_ref(1, 66, 0);
        build_ref(2, 128, 5);
        build_ref(3, 195, 9);

        running = 1;
        // R8: four back-to-back injections all accepted
        for (int c = 0; c < NCTX; c++) begin
            @(posedge clk); #1;
            ins_en = 1'b1;
            ins_pc = (c == 0) ? W'(0) : (c == 1) ? W'(66) : (c == 2) ? W'(128) : W'(195);
            ins_acc = (c == 2) ? W'(5) : (c == 3) ? W'(9) : W'(0);
            @(negedge clk);
            chk(ins_ack == 1'b1, (c == 0) ? "R1" : "R8", "injection into empty slot", int'(ins_ack), 1);
        end
        // R8: ring full, request refused and must leave no trace
        @(posedge clk); #1;
        ins_pc = W'(300); ins_acc = W'(1);
        @(negedge clk);
        chk(ins_ack == 1'b0, "R8", "injection into full ring", int'(ins_ack), 0);
        @(posedge clk); #1;
        ins_en = 1'b0;

        // R7: scratch writes steal each bank's port in turn
        for (int i = 0; i < 8; i++) begin
            put(256 + i * 5, 0, i);
            repeat (5) @(posedge clk);
        end

        repeat (300) @(posedge clk);
        for (int c = 0; c < NCTX; c++)
            chk(expq[c].size() == 0, "R4", "context did not complete its steps", expq[c].size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule